// File: doc/BRIEF.md
# Indirect-Indexed Video Memory Access Port

This block is the host-side face of a display controller. A CPU reaches it through two byte-wide ports. Writing the index port chooses one internal register, and reading the index port returns a status byte. The data port then reads or writes whichever register is currently chosen. The block keeps a 16-bit memory pointer, entered as a high byte and a low byte in two internal registers. Through a data register it moves single bytes into and out of a local video RAM, and the pointer advances by one after each transfer.

Every RAM transfer makes the controller busy for a fixed number of cycles, and the ready bit in the status byte shows this. The working pointer loads only when the low-byte register is written. At that moment it takes the high-byte register's current value, so the high byte must be written before the low byte. A data-port access made while the controller is busy is discarded, and a sticky overrun flag records it.

Top module: `vmem_access_port`

## Requirements
- R1: After reset, status reads 0x80, registers 18, 19 and 30 read 0x00, and the working pointer is 0x0000.
- R2: A write to the index port (bus_port=0) selects a register. A data-port (bus_port=1) access then reads or writes that register. Registers 18 and 19 read back the value last written to them.
- R3: A read of the index port returns status. Bit 7 is ready, bit 6 is overrun, and bits 5..0 are 0.
- R4: Writing register 19 loads the working pointer with {register 18, written byte}. Writing register 18 alone leaves the working pointer unchanged.
- R5: A write to register 31 stores the byte in RAM at the working pointer and then adds 1 to the pointer. The RAM holds 2**RAM_AW bytes and is indexed by the pointer's low RAM_AW bits.
- R6: A read of register 31 returns the RAM byte at the working pointer and then adds 1 to the pointer.
- R7: After an accepted register-31 access, ready reads 0 in status reads strobed on the next BUSY_CYCLES cycles, and reads 1 after that.
- R8: A data-port access strobed while ready is 0 is discarded and sets the overrun bit. The bit stays set until reset. A discarded read returns 0xFF.
- R9: The working pointer wraps from 0xFFFF to 0x0000, for reads and for writes alike.
- R10: Register 30 is plain read/write storage. Accessing it does not move the pointer and does not clear ready.
- R11: Any register index other than 18, 19, 30 and 31 reads 0xFF, and writes to it are ignored.
- R12: bus_rdata presents the result of a read strobe from the following cycle and holds it until the next read strobe. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_port | input | 1 | 0 = index/status port, 1 = data port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid from the cycle after a read strobe |

## Verification
The bench builds the block with its default values: BUSY_CYCLES of 4 and RAM_AW of 10. With a busy window of four cycles, the bench can count the exact number of not-ready status reads after each transfer, and it can place an access in the middle of the window to force the discard path. The 1 KiB RAM lets the bench model every location. It also makes the addresses 0xFFFF and 0x0000 land on distinct cells, so the pointer wrap can be seen through read-back.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

    // Register indices decoded on the data port; software depends on these.
    localparam logic [7:0] REG_PTR_HI = 8'd18;
    localparam logic [7:0] REG_PTR_LO = 8'd19;
    localparam logic [7:0] REG_COUNT  = 8'd30;
    localparam logic [7:0] REG_DATA   = 8'd31;

    localparam logic [7:0] UNMAPPED_READ = 8'hFF;

    typedef struct packed {
        logic [7:0]  sel;       // selected register index
        logic [7:0]  ptr_hi;    // register 18
        logic [7:0]  ptr_lo;    // register 19
        logic [7:0]  count;     // register 30
        logic [15:0] ptr;       // working pointer
        logic        ovr;       // sticky overrun
        logic        from_ram;  // last read result comes from RAM
        logic [7:0]  rd;        // last non-RAM read result
    } port_state_t;

endpackage

// File: rtl/vmp_busy_timer.sv
module vmp_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    // R7: a started transfer drops ready on the next cycle
    p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    // R7: the window never exceeds its configured length
    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R8: a new transfer never starts inside a busy window
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready);

endmodule

// File: rtl/vmp_ram.sv
module vmp_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;

    // R5: one transfer direction per cycle
    p_single_op_r5: assert property (@(posedge clk) !(we && re));

endmodule

// File: rtl/vmem_access_port.sv
module vmem_access_port
    import vmp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int RAM_AW      = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_port,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    port_state_t st_d, st_q;

    logic             ready;
    logic             xfer_start;
    logic             ram_we, ram_re;
    logic [7:0]       ram_rdata;
    logic             idx_acc, dat_acc, dat_ok;

    assign idx_acc = bus_cs && !bus_port;
    assign dat_acc = bus_cs &&  bus_port;
    assign dat_ok  = dat_acc && ready;

    always_comb begin
        st_d       = st_q;
        xfer_start = 1'b0;
        ram_we     = 1'b0;
        ram_re     = 1'b0;

        if (idx_acc) begin
            if (bus_we) begin
                st_d.sel = bus_wdata;
            end else begin
                st_d.rd       = {ready, st_q.ovr, 6'b0};
                st_d.from_ram = 1'b0;
            end
        end

        if (dat_acc && !ready) begin
            st_d.ovr = 1'b1;
            if (!bus_we) begin
                st_d.rd       = UNMAPPED_READ;
                st_d.from_ram = 1'b0;
            end
        end else if (dat_ok) begin
            unique case (st_q.sel)
                REG_PTR_HI: begin
                    if (bus_we) st_d.ptr_hi = bus_wdata;
                    else begin
                        st_d.rd       = st_q.ptr_hi;
                        st_d.from_ram = 1'b0;
                    end
                end
                REG_PTR_LO: begin
                    if (bus_we) begin
                        st_d.ptr_lo = bus_wdata;
                        st_d.ptr    = {st_q.ptr_hi, bus_wdata};
                    end else begin
                        st_d.rd       = st_q.ptr_lo;
                        st_d.from_ram = 1'b0;
                    end
                end
                REG_COUNT: begin
                    if (bus_we) st_d.count = bus_wdata;
                    else begin
                        st_d.rd       = st_q.count;
                        st_d.from_ram = 1'b0;
                    end
                end
                REG_DATA: begin
                    xfer_start = 1'b1;
                    st_d.ptr   = st_q.ptr + 16'd1;
                    if (bus_we) ram_we = 1'b1;
                    else begin
                        ram_re        = 1'b1;
                        st_d.from_ram = 1'b1;
                    end
                end
                default: begin
                    if (!bus_we) begin
                        st_d.rd       = UNMAPPED_READ;
                        st_d.from_ram = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    vmp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer_start),
        .ready (ready)
    );

    vmp_ram #(.AW(RAM_AW)) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (st_q.ptr[RAM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    assign bus_rdata = st_q.from_ram ? ram_rdata : st_q.rd;

    // R4: a low-byte write latches the high register held at that moment
    p_ptr_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ok && bus_we && st_q.sel == REG_PTR_LO)
        |=> st_q.ptr == {$past(st_q.ptr_hi), $past(bus_wdata)});

    // R5: an accepted data transfer advances the pointer by one (R9 wrap included)
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ok && st_q.sel == REG_DATA)
        |=> st_q.ptr == $past(st_q.ptr) + 16'd1);

    // R10: without a low-byte write or data transfer the pointer holds
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_ok && (st_q.sel == REG_DATA || (bus_we && st_q.sel == REG_PTR_LO)))
        |=> $stable(st_q.ptr));

    // R8: overrun is sticky
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);

    // R8: an access during busy raises overrun and touches no RAM
    p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && !ready) |=> st_q.ovr);
    p_drop_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(ram_we || ram_re));

endmodule

// File: tb/vmem_access_port_tb_top.sv
module vmem_access_port_tb_top;
    localparam int BUSY = 4;
    localparam int AW   = 10;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_port = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    always #10 clk = ~clk;

    vmem_access_port #(.BUSY_CYCLES(BUSY), .RAM_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_port(bus_port),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0]  m_hi = 0, m_lo = 0, m_cnt = 0;
    logic [15:0] m_ptr = 0;
    logic        m_ovr = 0;
    logic [7:0]  m_mem [DEPTH];
    bit          m_valid [DEPTH];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_exp(input bit rdy);
        return {rdy, m_ovr, 6'b0};
    endfunction

    function automatic logic [7:0] reg_exp(input logic [7:0] idx);
        case (idx)
            8'd18:   return m_hi;
            8'd19:   return m_lo;
            8'd30:   return m_cnt;
            default: return 8'hFF;
        endcase
    endfunction

    // one strobe, starts and ends at a falling edge
    task automatic op(input logic port, input logic we, input logic [7:0] wd,
                      output logic [7:0] rd);
        bus_cs = 1'b1; bus_port = port; bus_we = we; bus_wdata = wd;
        @(negedge clk);
        bus_cs = 1'b0;
        rd = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 64; i++) begin
            op(1'b0, 1'b0, 8'h00, s);
            if (s[7]) return;
        end
    endtask

    task automatic sel_reg(input logic [7:0] idx);
        logic [7:0] d;
        op(1'b0, 1'b1, idx, d);
    endtask

    // modelled, ready-guarded register access
    task automatic acc(input logic [7:0] idx, input logic we, input logic [7:0] wd,
                       input string req, output logic [7:0] rd);
        logic [7:0] exp;
        bit known;
        sel_reg(idx);
        wait_ready();
        exp = reg_exp(idx);
        known = 1'b1;
        if (idx == 8'd31) begin
            exp = m_mem[m_ptr[AW-1:0]];
            known = m_valid[m_ptr[AW-1:0]];
        end
        op(1'b1, we, wd, rd);
        if (we) begin
            case (idx)
                8'd18: m_hi = wd;
                8'd19: begin m_lo = wd; m_ptr = {m_hi, wd}; end
                8'd30: m_cnt = wd;
                8'd31: begin
                    m_mem[m_ptr[AW-1:0]] = wd;
                    m_valid[m_ptr[AW-1:0]] = 1'b1;
                end
                default: ;
            endcase
        end else if (known) begin
            chk(req, rd, exp);
        end
        if (idx == 8'd31) m_ptr = m_ptr + 16'd1;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        logic [7:0] d;
        acc(8'd18, 1'b1, p[15:8], "R4", d);
        acc(8'd19, 1'b1, p[7:0], "R4", d);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [7:0] d, s, keep;
        int busy_n;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_valid[i] = 0; end
        void'($urandom(32'h1F2E3D4C));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 / R3: reset state
        op(1'b0, 1'b0, 8'h00, s);
        chk("R1 status", s, 8'h80);
        chk("R3 status bits", s & 8'h3F, 8'h00);
        acc(8'd18, 1'b0, 8'h00, "R1 reg18", d);
        acc(8'd19, 1'b0, 8'h00, "R1 reg19", d);
        acc(8'd30, 1'b0, 8'h00, "R1 reg30", d);

        // R2: pointer registers read back
        set_ptr(16'h1234);
        acc(8'd18, 1'b0, 8'h00, "R2 reg18", d);
        acc(8'd19, 1'b0, 8'h00, "R2 reg19", d);

        // R5 / R7: write, then count busy status reads
        sel_reg(8'd31);
        wait_ready();
        op(1'b1, 1'b1, 8'hA5, d);
        m_mem[m_ptr[AW-1:0]] = 8'hA5; m_valid[m_ptr[AW-1:0]] = 1'b1; m_ptr++;
        busy_n = 0;
        for (int i = 0; i < 20; i++) begin
            op(1'b0, 1'b0, 8'h00, s);
            if (s[7]) break;
            busy_n++;
        end
        chk("R7 busy length", 8'(busy_n), 8'(BUSY));
        chk("R7 ready returns", s, status_exp(1'b1));
        acc(8'd31, 1'b1, 8'h5A, "R5", d);

        // R6: read back consecutive bytes
        set_ptr(16'h1234);
        acc(8'd31, 1'b0, 8'h00, "R6 first", d);
        acc(8'd31, 1'b0, 8'h00, "R5 consecutive", d);

        // R12: result holds across idle and writes
        keep = bus_rdata;
        idle(5);
        chk("R12 hold idle", bus_rdata, keep);
        sel_reg(8'd30);
        chk("R12 hold write", bus_rdata, keep);

        // R4: high byte alone does not move the pointer
        set_ptr(16'h1240);
        acc(8'd18, 1'b1, 8'h77, "R4", d);
        acc(8'd31, 1'b1, 8'h3C, "R4", d);
        set_ptr(16'h1240);
        acc(8'd31, 1'b0, 8'h00, "R4 latch", d);
        acc(8'd18, 1'b0, 8'h00, "R2 reg18 after", d);

        // R10: count register has no side effect
        acc(8'd30, 1'b1, 8'h99, "R10", d);
        op(1'b0, 1'b0, 8'h00, s);
        chk("R10 ready kept", s, status_exp(1'b1));
        acc(8'd30, 1'b0, 8'h00, "R10 readback", d);
        acc(8'd19, 1'b1, 8'h41, "R10", d);
        acc(8'd30, 1'b1, 8'h98, "R10", d);
        acc(8'd31, 1'b1, 8'h6D, "R10", d);
        set_ptr(16'h1241);
        acc(8'd31, 1'b0, 8'h00, "R10 pointer unmoved", d);

        // R11: unmapped indices
        acc(8'd5, 1'b1, 8'h44, "R11", d);
        acc(8'd5, 1'b0, 8'h00, "R11 idx5", d);
        acc(8'd40, 1'b0, 8'h00, "R11 idx40", d);
        op(1'b0, 1'b0, 8'h00, s);
        chk("R11 status", s, status_exp(1'b1));

        // R8: access during busy is discarded
        set_ptr(16'h0100);
        sel_reg(8'd31);
        wait_ready();
        op(1'b1, 1'b1, 8'h11, d);
        op(1'b1, 1'b1, 8'h22, d);
        m_mem[10'h100] = 8'h11; m_valid[10'h100] = 1'b1;
        m_ptr = 16'h0101;
        m_ovr = 1'b1;
        op(1'b0, 1'b0, 8'h00, s);
        chk("R8 overrun busy", s, status_exp(1'b0));
        acc(8'd31, 1'b1, 8'h33, "R8", d);
        set_ptr(16'h0100);
        acc(8'd31, 1'b0, 8'h00, "R8 kept", d);
        acc(8'd31, 1'b0, 8'h00, "R8 no skip", d);
        op(1'b1, 1'b0, 8'h00, d);
        chk("R8 dropped read", d, 8'hFF);
        wait_ready();
        op(1'b0, 1'b0, 8'h00, s);
        chk("R8 sticky", s, 8'hC0);

        // R9: wrap
        set_ptr(16'hFFFF);
        acc(8'd31, 1'b1, 8'hAB, "R9", d);
        acc(8'd31, 1'b1, 8'hCD, "R9", d);
        set_ptr(16'h0000);
        acc(8'd31, 1'b0, 8'h00, "R9 zero", d);
        set_ptr(16'hFFFF);
        acc(8'd31, 1'b0, 8'h00, "R9 top", d);
        acc(8'd31, 1'b0, 8'h00, "R9 read wrap", d);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] idx;
            logic we;
            case ($urandom_range(0, 7))
                0: idx = 8'd18;
                1: idx = 8'd19;
                2: idx = 8'd30;
                3: idx = 8'($urandom_range(0, 63));
                default: idx = 8'd31;
            endcase
            we = 1'($urandom_range(0, 1));
            acc(idx, we, 8'($urandom), "R2 random", d);
        end
        op(1'b0, 1'b0, 8'h00, s);
        chk("R3 final status", s & 8'h7F, {1'b0, m_ovr, 6'b0});

        done = 1'b1;
        report();
    end
endmodule